// File: doc/BRIEF.md
# Interrupt CPU Interface with Acknowledge and End-of-Interrupt

This block sits between an interrupt distributor and one processor. For each interrupt ID it receives a pending flag, a group bit and a priority value. It passes on only those IDs whose group is enabled, whose priority value lies strictly below a programmable mask, and whose urgency is strictly greater than that of every interrupt the processor is still servicing. Of these, it picks the most urgent one and drives it onto either the IRQ line or the FIQ line. The line depends on the group and on a routing bit in the control register.

Software reads the acknowledge register to take the selected interrupt. The returned word holds the interrupt ID and the number of the processor that raised it. The read moves that ID from pending to active and sends a one-cycle strobe to the distributor so that it can drop the pending state. Software retires the interrupt by writing the same word to the end-of-interrupt register. A lower priority value means more urgent.

The register bus is a request channel with valid/ready plus a response channel. The request channel never applies back-pressure: ready is held high, so a request is taken in every cycle where valid is high. Each read produces exactly one response in the next cycle. The response channel has no ready, so the reader must accept it.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, irq_o and fiq_o are low, the control and mask registers read 0, and an acknowledge read returns 1023.
- R2: The registers sit at these byte offsets: control at 0x000, priority mask at 0x004, acknowledge at 0x00C, end-of-interrupt at 0x010. Control keeps only bit 0 (group 0 enable), bit 1 (group 1 enable) and bit 3 (group 0 to FIQ); all other control bits read 0. The mask keeps its low PRIO_W bits.
- R3: An interrupt qualifies only if its priority value is strictly below the mask. With a mask of 0x80, priority 0x7F is admitted and priority 0x80 is not.
- R4: Among qualifying interrupts, the lowest priority value wins. A tie goes to the lower ID.
- R5: An acknowledge read returns the ID in bits [9:0] and the source processor in bits [12:10], with all other bits zero. The read marks the ID active and pulses ack_strobe_o with ack_id_o one cycle later.
- R6: An acknowledge read when nothing qualifies returns 1023, changes no state and gives no strobe.
- R7: While interrupts are active, a pending interrupt qualifies only if its priority value is strictly below the lowest priority value among the active ones.
- R8: An end-of-interrupt write with an active ID in bits [9:0] retires that ID. A write whose ID is not active, or is out of range, is ignored.
- R9: An interrupt whose group is disabled is neither signalled nor acknowledged (group bit 1 means group 1). The mask stays writable while both groups are disabled.
- R10: A group 1 interrupt drives irq_o. A group 0 interrupt drives fiq_o when control bit 3 is set, and irq_o otherwise. The two lines are never high together. The lines follow the selection with one cycle of latency.
- R11: req_ready_o is always high. Every read request gives rsp_valid_o high in the next cycle, carrying the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_IDS | Pending flag per ID from the distributor |
| grp_i | input | NUM_IDS | Group per ID (1 = group 1) |
| prio_i | input | NUM_IDS*PRIO_W | Priority per ID, ID n at bits [n*PRIO_W +: PRIO_W] |
| src_cpu_i | input | NUM_IDS*CPU_W | Source processor per ID |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read data |
| ack_strobe_o | output | 1 | One-cycle pulse: an ID was acknowledged |
| ack_id_o | output | IDX_W | The acknowledged ID |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Directed cases place priorities on both sides of the mask boundary, to separate strict from inclusive comparison. They create equal-priority ties, to check that the lower ID wins. They stack active interrupts at equal and at higher urgency, to tell blocking apart from preemption. They send end-of-interrupt writes for IDs that are not active, to show those writes are ignored. Routing is tried with every combination of group and FIQ bit. Random rounds then redraw pending flags, priorities, groups, enables and the mask. In each round, the acknowledged word and the state of the lines are compared with a model of the bench. This catches faults that show up only when many interrupts compete and several are active at once.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ACK_ID_W    = 10;
  localparam int SPURIOUS_ID = 1023;
  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_PMASK = 12'h004;
  localparam logic [11:0] OFF_ACK   = 12'h00C;
  localparam logic [11:0] OFF_EOI   = 12'h010;
  localparam int CTL_G0  = 0;
  localparam int CTL_G1  = 1;
  localparam int CTL_FIQ = 3;
endpackage

// File: rtl/cpuif_select.sv
module cpuif_select #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IDS-1:0]        cand,
  input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
  output logic                      sel_valid,
  output logic [IDX_W-1:0]          sel_id
);
  logic [PRIO_W-1:0] best_prio;

  // Strict comparison while scanning upward keeps the lower ID on ties.
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cand[i] && (!sel_valid || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        sel_valid = 1'b1;
        sel_id    = IDX_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  AST_SEL_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> cand[sel_id]); // R4
  AST_SEL_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> sel_valid); // R4
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_valid,
  input  logic [IDX_W-1:0]          set_id,
  input  logic                      clr_valid,
  input  logic [IDX_W-1:0]          clr_id,
  input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
  output logic [NUM_IDS-1:0]        active,
  output logic [PRIO_W:0]           run_prio
);
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        active[g] <= 1'b0;
      else if (set_valid && set_id == IDX_W'(g))
        active[g] <= 1'b1;
      else if (clr_valid && clr_id == IDX_W'(g))
        active[g] <= 1'b0;
    end
  end

  // Idle running priority is one above the largest priority value.
  always_comb begin
    run_prio = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < NUM_IDS; i++)
      if (active[i] && {1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < run_prio)
        run_prio = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
  end

  AST_SET_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> !active[set_id]); // R5
  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && !active[clr_id] && !set_valid |=> $stable(active)); // R8
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
  import cpuif_pkg::*;
#(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 8,
  parameter int CPU_W   = 3,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IDS-1:0]        pend_i,
  input  logic [NUM_IDS-1:0]        grp_i,
  input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
  input  logic [NUM_IDS*CPU_W-1:0]  src_cpu_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_write_i,
  input  logic [11:0]               req_addr_i,
  input  logic [31:0]               req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [31:0]               rsp_data_o,
  output logic                      ack_strobe_o,
  output logic [IDX_W-1:0]          ack_id_o,
  output logic                      irq_o,
  output logic                      fiq_o
);
  logic                 ctl_g0_q, ctl_g1_q, ctl_fiq_q;
  logic [PRIO_W-1:0]    pmask_q;
  logic [NUM_IDS-1:0]   active, cand;
  logic [PRIO_W:0]      run_prio;
  logic                 sel_valid;
  logic [IDX_W-1:0]     sel_id;
  logic                 rd, wr, is_ack_rd, set_valid, clr_valid;
  logic [ACK_ID_W-1:0]  eoi_id;
  logic [31:0]          rd_mux;
  logic                 fiq_d, irq_d;
  logic                 wdata_unused;

  assign req_ready_o  = 1'b1;
  assign rd           = req_valid_i && !req_write_i;
  assign wr           = req_valid_i && req_write_i;
  assign is_ack_rd    = rd && req_addr_i == OFF_ACK;
  assign set_valid    = is_ack_rd && sel_valid;
  assign eoi_id       = req_wdata_i[ACK_ID_W-1:0];
  assign clr_valid    = wr && req_addr_i == OFF_EOI && eoi_id < ACK_ID_W'(NUM_IDS);
  assign wdata_unused = ^{req_wdata_i[31:ACK_ID_W]};

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_cand
    logic grp_ok;
    assign grp_ok  = grp_i[g] ? ctl_g1_q : ctl_g0_q;
    assign cand[g] = pend_i[g] && !active[g] && grp_ok
                     && prio_i[g*PRIO_W +: PRIO_W] < pmask_q
                     && {1'b0, prio_i[g*PRIO_W +: PRIO_W]} < run_prio;
  end

  cpuif_select #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) i_select (
    .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(prio_i),
    .sel_valid(sel_valid), .sel_id(sel_id)
  );

  cpuif_active #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) i_active (
    .clk(clk), .rst_n(rst_n),
    .set_valid(set_valid), .set_id(sel_id),
    .clr_valid(clr_valid), .clr_id(IDX_W'(eoi_id)),
    .prio_flat(prio_i), .active(active), .run_prio(run_prio)
  );

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      OFF_CTRL:  rd_mux = {28'd0, ctl_fiq_q, 1'b0, ctl_g1_q, ctl_g0_q};
      OFF_PMASK: rd_mux = 32'(pmask_q);
      OFF_ACK:   rd_mux = sel_valid
                   ? 32'({src_cpu_i[int'(sel_id)*CPU_W +: CPU_W], ACK_ID_W'(sel_id)})
                   : 32'(SPURIOUS_ID);
      default:   rd_mux = '0;
    endcase
  end

  assign fiq_d = sel_valid && !grp_i[sel_id] && ctl_fiq_q;
  assign irq_d = sel_valid && !fiq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_g0_q     <= 1'b0;
      ctl_g1_q     <= 1'b0;
      ctl_fiq_q    <= 1'b0;
      pmask_q      <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
      ack_strobe_o <= 1'b0;
      ack_id_o     <= '0;
      irq_o        <= 1'b0;
      fiq_o        <= 1'b0;
    end else begin
      if (wr && req_addr_i == OFF_CTRL) begin
        ctl_g0_q  <= req_wdata_i[CTL_G0];
        ctl_g1_q  <= req_wdata_i[CTL_G1];
        ctl_fiq_q <= req_wdata_i[CTL_FIQ];
      end
      if (wr && req_addr_i == OFF_PMASK)
        pmask_q <= req_wdata_i[PRIO_W-1:0];
      rsp_valid_o  <= rd;
      if (rd)
        rsp_data_o <= rd_mux;
      ack_strobe_o <= set_valid;
      if (set_valid)
        ack_id_o <= sel_id;
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o)); // R10
  AST_RSP_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid_o); // R11
  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_ack_rd && !sel_valid |=> !ack_strobe_o && rsp_data_o == 32'(SPURIOUS_ID)); // R6
  AST_GROUPS_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_g0_q && !ctl_g1_q |=> !irq_o && !fiq_o); // R9
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pmask_q == '0 |=> !irq_o && !fiq_o); // R3
endmodule

// File: tb/test_irq_cpu_iface.sv
module test_irq_cpu_iface;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int PW = 8;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pend_v = '0, grp_v = '0;
  logic [N*PW-1:0] prio_v = '0;
  logic [N*CW-1:0] src_v = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, ack_strobe, irq, fiq;
  logic [31:0] rsp_data;
  logic [4:0] ack_id;

  irq_cpu_iface i_irq_cpu_iface (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_v), .grp_i(grp_v), .prio_i(prio_v),
    .src_cpu_i(src_v), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .ack_strobe_o(ack_strobe),
    .ack_id_o(ack_id), .irq_o(irq), .fiq_o(fiq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  bit pend[N], grp[N], act[N];
  logic [7:0] prio[N];
  logic [2:0] src[N];
  bit m_g0, m_g1, m_fiq;
  logic [7:0] m_pmr;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint a, longint e);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, a, e);
    end
  endtask

  task automatic apply();
    for (int i = 0; i < N; i++) begin
      pend_v[i] = pend[i];
      grp_v[i] = grp[i];
      prio_v[i*PW +: PW] = prio[i];
      src_v[i*CW +: CW] = src[i];
    end
  endtask

  function automatic int exp_sel();
    int best = -1;
    int run = 256;
    for (int i = 0; i < N; i++) if (act[i] && int'(prio[i]) < run) run = int'(prio[i]);
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !act[i] && (grp[i] ? m_g1 : m_g0) && prio[i] < m_pmr
          && int'(prio[i]) < run && (best < 0 || prio[i] < prio[best]))
        best = i;
    end
    return best;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R11", "rsp_valid", rsp_valid, 1);
    d = rsp_data;
  endtask

  task automatic set_ctl(bit g0, bit g1, bit f);
    m_g0 = g0; m_g1 = g1; m_fiq = f;
    bus_write(12'h000, {28'd0, f, 1'b0, g1, g0});
  endtask

  task automatic set_pmr(logic [7:0] p);
    m_pmr = p;
    bus_write(12'h004, {24'd0, p});
  endtask

  task automatic do_ack(string req);
    int e;
    logic [31:0] d, w;
    apply();
    e = exp_sel();
    w = (e < 0) ? 32'd1023 : {19'd0, src[e], 10'(e)};
    bus_read(12'h00C, d);
    chk(d === w, req, "ack word", d, w);
    chk(ack_strobe === (e >= 0), "R5", "ack strobe", ack_strobe, e >= 0);
    if (e >= 0) begin
      chk(ack_id === 5'(e), "R5", "ack id", ack_id, e);
      act[e] = 1; pend[e] = 0;
    end
    apply();
  endtask

  task automatic do_eoi(int id, logic [2:0] s);
    bus_write(12'h010, {19'd0, s, 10'(id)});
    if (id < N) act[id] = 0;
  endtask

  task automatic chk_lines(string req);
    int e;
    bit ef, ei;
    apply();
    @(negedge clk); @(negedge clk);
    e = exp_sel();
    ef = e >= 0 && !grp[e] && m_fiq;
    ei = e >= 0 && !ef;
    chk(irq === ei, req, "irq_o", irq, ei);
    chk(fiq === ef, req, "fiq_o", fiq, ef);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      if (act[i]) do_eoi(i, 3'd0);
      pend[i] = 0; grp[i] = 0; prio[i] = 8'hFF; src[i] = 3'(i);
    end
    apply();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      pend[i] = 0; grp[i] = 0; act[i] = 0; prio[i] = 8'hFF; src[i] = 3'(i);
    end
    m_g0 = 0; m_g1 = 0; m_fiq = 0; m_pmr = 0;
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(irq === 0 && fiq === 0, "R1", "lines after reset", {irq, fiq}, 0);
    chk(req_ready === 1, "R11", "ready", req_ready, 1);
    bus_read(12'h000, d); chk(d === 0, "R1", "ctrl reset", d, 0);
    bus_read(12'h004, d); chk(d === 0, "R1", "mask reset", d, 0);
    do_ack("R1");

    // R2 register map and kept bits
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_read(12'h000, d); chk(d === 32'hB, "R2", "ctrl kept bits", d, 32'hB);
    bus_write(12'h004, 32'h0000_01FF);
    bus_read(12'h004, d); chk(d === 32'hFF, "R2", "mask width", d, 32'hFF);

    // R9 groups off, mask still writable
    set_ctl(0, 0, 0);
    set_pmr(8'hF0);
    bus_read(12'h004, d); chk(d === 32'hF0, "R9", "mask with groups off", d, 32'hF0);
    pend[4] = 1; prio[4] = 8'h10; grp[4] = 1;
    chk_lines("R9");
    do_ack("R9");
    set_ctl(0, 1, 0); grp[4] = 0;
    chk_lines("R9");
    do_ack("R9");
    clear_all();

    // R3 strict mask boundary
    set_ctl(1, 1, 0);
    set_pmr(8'h80);
    pend[5] = 1; prio[5] = 8'h80; grp[5] = 1; src[5] = 3'd6;
    chk_lines("R3");
    do_ack("R3");
    prio[5] = 8'h7F;
    chk_lines("R3");
    do_ack("R5");
    do_eoi(5, 3'd6);
    clear_all();

    // R4 tie break, R7 blocking and preemption, R8 ignored EOI
    pend[3] = 1; prio[3] = 8'h10;
    pend[9] = 1; prio[9] = 8'h10;
    pend[20] = 1; prio[20] = 8'h20;
    do_ack("R4");
    do_ack("R7");
    pend[30] = 1; prio[30] = 8'h05;
    do_ack("R7");
    do_eoi(30, 3'd0);
    do_eoi(3, 3'd0);
    do_ack("R8");
    do_eoi(20, 3'd0);
    do_ack("R8");
    do_eoi(40, 3'd0);
    do_ack("R8");
    do_eoi(9, 3'd0);
    do_ack("R8");
    clear_all();

    // R10 routing
    pend[7] = 1; prio[7] = 8'h01; grp[7] = 0;
    set_ctl(1, 1, 1); chk_lines("R10");
    set_ctl(1, 1, 0); chk_lines("R10");
    grp[7] = 1;
    set_ctl(1, 1, 1); chk_lines("R10");
    clear_all();

    // Random rounds
    for (int it = 0; it < 400; it++) begin
      for (int i = 0; i < N; i++) begin
        pend[i] = ($urandom % 4) == 0;
        grp[i] = $urandom % 2;
        prio[i] = 8'($urandom % 64);
        src[i] = 3'($urandom);
      end
      if ((it % 16) == 0) set_ctl($urandom % 2, $urandom % 2, $urandom % 2);
      if ((it % 8) == 0) set_pmr(8'($urandom % 72));
      chk_lines("R10");
      case ($urandom % 3)
        0, 1: do_ack("R4");
        default: do_eoi($urandom % 40, 3'($urandom));
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule